// File: doc/BRIEF.md
# Torus Wormhole Switch with Source-Chosen Routes

This is a five-port switch for one tile of a two-dimensional torus network-on-chip. Four ports face the neighbouring tiles (north, south, east, west), and the fifth faces the local tile. Each port has one incoming and one outgoing 32-bit flit link. A link moves at most one flit per clock cycle.

Packets travel wormhole-style. The first flit of a packet carries a route that the sending tile chose. That route gives the order of the two dimensions, the direction of travel in each dimension, and the number of hops left in each. The switch never adapts the route. It reads the head flit, sends it one hop in the direction the head asks for, and lowers the hop count for that dimension. Because the direction is a field of the head, a sender can route a packet the long way around the torus through the wrap-around links. The switch makes no distinction for that case.

Each input has a small queue. Each output locks to one input from the head flit until the tail flit. Heads that compete for a free output are granted in round-robin order.

Top module: `torus_wh_switch`

## Requirements
- R1: While reset is held, every `out_vld` bit and every `in_bp` bit is low.
- R2: An input flit is taken on a clock edge only when its `in_vld` is high and its `in_bp` is low. Each input queue holds 4 flits. `in_bp` goes high when fewer than 2 entries are free. With its output stalled, an input therefore accepts exactly 4 flits before `in_bp` rises.
- R3: An output that shows `out_vld` high while its `out_bp` is high keeps `out_vld` and `out_flit` unchanged on the next cycle.
- R4: The head flit layout is as follows.
  - Bits [31:30] give the type: 01 head, 00 body, 10 tail, 11 single-flit packet.
  - Bit 29 selects Y-first order.
  - Bit 28 gives the X direction: 0 is east, 1 is west.
  - Bit 27 gives the Y direction: 0 is north, 1 is south.
  - Bits [26:23] hold the X hops left, and bits [22:19] hold the Y hops left.
  - A head with both hop counts at zero leaves on the local port.
- R5: When bit 29 is 0, a head with a nonzero X count goes east or west according to bit 28. Once the X count is zero, the head goes north or south according to bit 27. Port indices are north 0, south 1, east 2, west 3, local 4.
- R6: When bit 29 is 1, the Y count is used up first, on the north or south port. Only then does the head go east or west.
- R7: A forwarded head equals the incoming head with the count of the travelled dimension lowered by one. This holds for any count up to 15, which covers the long way round. A head that leaves on the local port is unchanged.
- R8: After a multi-flit head leaves an output, that output carries only the flits of the same packet until its tail. Body and tail flits pass bit for bit unchanged and in order.
- R9: Packet heads that compete for a free output are granted in rotating order. After reset the search starts at input 0, and each grant moves the start to the input after the winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 5 | Per input port: a flit is offered on `in_flit` |
| in_flit | input | 160 | Incoming flits, port p at bits [32p+31:32p] |
| in_bp | output | 5 | Per input port: backpressure, the sender must hold its flit |
| out_vld | output | 5 | Per output port: a flit is presented on `out_flit` |
| out_flit | output | 160 | Outgoing flits, port p at bits [32p+31:32p] |
| out_bp | input | 5 | Per output port: backpressure from the receiving neighbour |

## Verification
The properties assume well-formed packets on each input. Every head (01) is followed by zero or more body flits and then a tail. A single-flit packet (11) stands alone. Senders hold a flit steady until it is taken, and a receiver drains each output within a bounded time.

The stimulus keeps to these rules. Each packet is built as one complete flit list per input. A flit stays on the link until the cycle it is taken. Random `out_bp` always releases again, and a forced stall is lifted once its check is done.

// File: rtl/torus_sw_pkg.sv
package torus_sw_pkg;
  localparam int FLIT_W  = 32;
  localparam int NPORT   = 5;
  localparam int HOP_W   = 4;

  // port numbering; the route logic depends on it
  localparam int P_NORTH = 0;
  localparam int P_SOUTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_WEST  = 3;
  localparam int P_LOCAL = 4;

  // bit 30 set: the flit opens a packet; bit 31 set: the flit closes it
  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } ftype_e;

  localparam int OPEN_B   = 30;
  localparam int CLOSE_B  = 31;
  localparam int YFIRST_B = 29;
  localparam int XNEG_B   = 28;
  localparam int YNEG_B   = 27;
  localparam int XH_LO    = 23;
  localparam int YH_LO    = 19;
endpackage

// File: rtl/sw_flit_fifo.sv
module sw_flit_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  front,
  output logic          empty,
  output logic [CW-1:0] count
);
  // DEPTH must be a power of two so the pointers wrap on their own
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign front = store[rd_ptr];
  assign empty = (count == '0);
endmodule

// File: rtl/sw_route_calc.sv
module sw_route_calc
  import torus_sw_pkg::*;
(
  input  logic [FLIT_W-1:0] flit_in,
  output logic [NPORT-1:0]  dest_oh,
  output logic [FLIT_W-1:0] flit_out
);
  logic [HOP_W-1:0] xh, yh;
  logic             at_dest, step_y;

  always_comb begin
    xh      = flit_in[XH_LO +: HOP_W];
    yh      = flit_in[YH_LO +: HOP_W];
    at_dest = (xh == '0) && (yh == '0);
    // Y first: spend Y hops while any remain; X first: move in Y only once X is spent
    step_y  = flit_in[YFIRST_B] ? (yh != '0) : (xh == '0);
    dest_oh  = '0;
    flit_out = flit_in;
    if (at_dest) begin
      dest_oh[P_LOCAL] = 1'b1;
    end else if (step_y) begin
      dest_oh[flit_in[YNEG_B] ? P_SOUTH : P_NORTH] = 1'b1;
      if (flit_in[OPEN_B]) flit_out[YH_LO +: HOP_W] = yh - HOP_W'(1);
    end else begin
      dest_oh[flit_in[XNEG_B] ? P_WEST : P_EAST] = 1'b1;
      if (flit_in[OPEN_B]) flit_out[XH_LO +: HOP_W] = xh - HOP_W'(1);
    end
  end
endmodule

// File: rtl/sw_out_port.sv
module sw_out_port #(
  parameter int NPORT = 5,
  parameter int W     = 32,
  localparam int IW   = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] head_req,
  input  logic [NPORT-1:0] nonempty,
  input  logic [NPORT*W-1:0] cand_flat,
  input  logic             link_bp,
  output logic             link_vld,
  output logic [W-1:0]     link_flit,
  output logic [NPORT-1:0] grant,
  output logic [NPORT-1:0] lock_oh
);
  logic          locked;
  logic [IW-1:0] owner, rr_last, win, sel;
  logic          found, can_load, go;
  logic [W-1:0]  mv_flit;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= NPORT; k++) begin
      if (!found && head_req[(int'(rr_last) + k) % NPORT]) begin
        found = 1'b1;
        win   = IW'((int'(rr_last) + k) % NPORT);
      end
    end
    can_load = !link_vld || !link_bp;
    sel      = locked ? owner : win;
    go       = can_load && (locked ? nonempty[owner] : found);
    mv_flit  = cand_flat[int'(sel)*W +: W];
    grant    = go ? (NPORT'(1) << sel) : '0;
    lock_oh  = locked ? (NPORT'(1) << owner) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      owner     <= '0;
      rr_last   <= IW'(NPORT - 1);
      link_vld  <= 1'b0;
      link_flit <= '0;
    end else if (go) begin
      link_vld  <= 1'b1;
      link_flit <= mv_flit;
      if (!locked) begin
        rr_last <= win;
        if (!mv_flit[W-1]) begin
          locked <= 1'b1;
          owner  <= win;
        end
      end else if (mv_flit[W-1]) begin
        locked <= 1'b0;
      end
    end else if (link_vld && !link_bp) begin
      link_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/torus_wh_switch.sv
module torus_wh_switch
  import torus_sw_pkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int BP_FREE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_vld,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]        in_bp,
  output logic [NPORT-1:0]        out_vld,
  output logic [NPORT*FLIT_W-1:0] out_flit,
  input  logic [NPORT-1:0]        out_bp
);
  localparam int CW       = $clog2(QDEPTH) + 1;
  localparam int BP_LEVEL = QDEPTH - BP_FREE;

  logic [NPORT-1:0]        q_pop, q_empty, bound;
  logic [FLIT_W-1:0]       q_front   [NPORT];
  logic [NPORT-1:0]        dest_oh   [NPORT];
  logic [NPORT-1:0]        req_mat   [NPORT];
  logic [NPORT-1:0]        grant_mat [NPORT];
  logic [NPORT*FLIT_W-1:0] cand_flat;
  logic [NPORT*NPORT-1:0]  lock_flat;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [CW-1:0] fill;
    logic          take;
    assign in_bp[i] = (fill > CW'(BP_LEVEL));
    assign take     = in_vld[i] && !in_bp[i];

    sw_flit_fifo #(.W(FLIT_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(take), .push_data(in_flit[i*FLIT_W +: FLIT_W]),
      .pop(q_pop[i]), .front(q_front[i]),
      .empty(q_empty[i]), .count(fill)
    );

    sw_route_calc u_rt (
      .flit_in(q_front[i]),
      .dest_oh(dest_oh[i]),
      .flit_out(cand_flat[i*FLIT_W +: FLIT_W])
    );
  end

  // an input already holding an output lock must not compete again
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      bound[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) bound[i] = bound[i] | lock_flat[o*NPORT + i];
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_mat[o][i] = !q_empty[i] && !bound[i] && q_front[i][OPEN_B] && dest_oh[i][o];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      q_pop[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) q_pop[i] = q_pop[i] | grant_mat[o][i];
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    sw_out_port #(.NPORT(NPORT), .W(FLIT_W)) u_op (
      .clk(clk), .rst_n(rst_n),
      .head_req(req_mat[o]),
      .nonempty(~q_empty),
      .cand_flat(cand_flat),
      .link_bp(out_bp[o]),
      .link_vld(out_vld[o]),
      .link_flit(out_flit[o*FLIT_W +: FLIT_W]),
      .grant(grant_mat[o]),
      .lock_oh(lock_flat[o*NPORT +: NPORT])
    );
  end
endmodule

// File: rtl/torus_wh_switch_chk.sv
module torus_wh_switch_chk
  import torus_sw_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        in_vld,
  input logic [NPORT-1:0]        in_bp,
  input logic [NPORT-1:0]        out_vld,
  input logic [NPORT*FLIT_W-1:0] out_flit,
  input logic [NPORT-1:0]        out_bp,
  input logic [NPORT*NPORT-1:0]  lock_flat
);
  logic [NPORT-1:0] lock_col [NPORT];
  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++) lock_col[i][o] = lock_flat[o*NPORT + i];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[o] && out_bp[o]) |=> (out_vld[o] && $stable(out_flit[o*FLIT_W +: FLIT_W])));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    p_bp_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_bp[i]) |-> $past(in_vld[i] && !in_bp[i]));
    p_one_lock_per_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lock_col[i]));
  end

  p_local_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld[P_LOCAL] && out_flit[P_LOCAL*FLIT_W + OPEN_B]) |->
      (out_flit[P_LOCAL*FLIT_W + XH_LO +: HOP_W] == '0 &&
       out_flit[P_LOCAL*FLIT_W + YH_LO +: HOP_W] == '0));

  for (genvar o = P_NORTH; o <= P_SOUTH; o++) begin : g_ns
    p_x_done_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[o] && out_flit[o*FLIT_W + OPEN_B] && !out_flit[o*FLIT_W + YFIRST_B]) |->
        (out_flit[o*FLIT_W + XH_LO +: HOP_W] == '0));
  end

  for (genvar o = P_EAST; o <= P_WEST; o++) begin : g_ew
    p_y_done_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[o] && out_flit[o*FLIT_W + OPEN_B] && out_flit[o*FLIT_W + YFIRST_B]) |->
        (out_flit[o*FLIT_W + YH_LO +: HOP_W] == '0));
  end
endmodule

bind torus_wh_switch torus_wh_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bp(in_bp),
  .out_vld(out_vld), .out_flit(out_flit), .out_bp(out_bp), .lock_flat(lock_flat)
);

// File: tb/torus_wh_switch_test.sv
module torus_wh_switch_test;
  import torus_sw_pkg::*;
  localparam int W = 32, NP = 5, MAXF = 256, MAXPK = 512;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0]   in_vld = '0, in_bp, out_vld, out_bp = '0;
  logic [NP*W-1:0] in_flit = '0, out_flit;

  torus_wh_switch uut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
    .in_bp(in_bp), .out_vld(out_vld), .out_flit(out_flit), .out_bp(out_bp));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_pk = 0, n_done = 0, loc_n = 0;
  logic [31:0] src_q [NP][MAXF];
  int src_len [NP], src_idx [NP];
  bit pend [NP], in_pk [NP];
  int cur_id [NP];
  bit gaps_en = 0, bp_rand_en = 0, log_en = 0, ended = 0;
  logic [NP-1:0] bp_force = '0;
  int exp_port [MAXPK], exp_len [MAXPK], got_len [MAXPK], src_of [MAXPK];
  logic [31:0] exp_head [MAXPK];
  string exp_tag [MAXPK];
  int loc_log [8];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_body(int id, int s, int len);
    logic [1:0] ty;
    ty = (s == len - 1) ? 2'b10 : 2'b00;
    return {ty, 11'(id * 3 + s), 11'(id), 8'(s)};
  endfunction

  // R4..R7: expected output port and forwarded head
  function automatic void exp_route(logic [31:0] h, output int port, output logic [31:0] fh,
                                    output string tag);
    logic [3:0] xh, yh;
    bit mv_y;
    xh = h[26:23]; yh = h[22:19]; fh = h;
    if (xh == 0 && yh == 0) begin port = 4; tag = "R4"; return; end
    tag  = h[29] ? "R6" : "R5";
    mv_y = h[29] ? (yh != 0) : (xh == 0);
    if (mv_y) begin port = h[27] ? 1 : 0; fh[22:19] = yh - 4'd1; end
    else      begin port = h[28] ? 3 : 2; fh[26:23] = xh - 4'd1; end
  endfunction

  task automatic add_pkt(int src, bit yf, bit xn, bit yn, logic [3:0] xh, logic [3:0] yh, int len);
    int id;
    logic [31:0] h;
    id = n_pk;
    h = {(len == 1) ? 2'b11 : 2'b01, yf, xn, yn, xh, yh, 11'(id), 8'd0};
    exp_route(h, exp_port[id], exp_head[id], exp_tag[id]);
    exp_len[id] = len; got_len[id] = 0; src_of[id] = src;
    src_q[src][src_len[src]] = h;
    for (int s = 1; s < len; s++) src_q[src][src_len[src] + s] = mk_body(id, s, len);
    n_pk++;
    src_len[src] += len;
  endtask

  task automatic take(int o, logic [31:0] f);
    int id;
    id = int'(f[18:8]);
    if (id >= n_pk) begin check(0, "R8", f, 32'd0); return; end
    if (f[30]) begin
      check(!in_pk[o], "R8", f, 32'd0);
      check(o == exp_port[id], exp_tag[id], 32'(o), 32'(exp_port[id]));
      check(f == exp_head[id], "R7", f, exp_head[id]);
      got_len[id] = 1;
      if (!f[31]) begin in_pk[o] = 1; cur_id[o] = id; end
      if (log_en && o == 4 && loc_n < 8) begin loc_log[loc_n] = src_of[id]; loc_n++; end
    end else begin
      check(in_pk[o] && cur_id[o] == id, "R8", 32'(id), 32'(cur_id[o]));
      check(f == mk_body(id, got_len[id], exp_len[id]), "R8", f, mk_body(id, got_len[id], exp_len[id]));
      got_len[id]++;
      if (f[31]) in_pk[o] = 0;
    end
    if (got_len[id] == exp_len[id]) n_done++;
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // link engine: output backpressure, output capture, input driving
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int o = 0; o < NP; o++)
          out_bp[o] = bp_force[o] | (bp_rand_en && $urandom_range(2) == 0);
        for (int o = 0; o < NP; o++)
          if (out_vld[o] && !out_bp[o]) take(o, out_flit[o*W +: W]);
        for (int i = 0; i < NP; i++) begin
          if (pend[i]) begin src_idx[i]++; in_vld[i] = 0; end
          if (!in_vld[i] && src_idx[i] < src_len[i] && (!gaps_en || $urandom_range(3) != 0)) begin
            in_vld[i] = 1;
            in_flit[i*W +: W] = src_q[i][src_idx[i]];
          end
          pend[i] = in_vld[i] && !in_bp[i];
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: delivered %0d of %0d packets", n_done, n_pk);
    finish_up();
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    for (int i = 0; i < NP; i++) begin src_len[i] = 0; src_idx[i] = 0; pend[i] = 0; in_pk[i] = 0; cur_id[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check(out_vld == '0, "R1", 32'(out_vld), 32'd0);
    check(in_bp == '0, "R1", 32'(in_bp), 32'd0);
    check(out_flit[31:0] == '0, "R1", out_flit[31:0], 32'd0);

    // R9: four inputs, two single-flit local packets each, all offered together
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 4; i++) add_pkt(i, 0, 0, 0, 4'd0, 4'd0, 1);
    log_en = 1;
    @(negedge clk); rst_n = 1;
    wait (n_done == n_pk);
    log_en = 0;
    for (int k = 0; k < 8; k++) check(loc_log[k] == k % 4, "R9", 32'(loc_log[k]), 32'(k % 4));

    // R2/R3: local output stalled, input 4 offers six local packets
    @(negedge clk);
    bp_force[4] = 1;
    base = src_len[4];
    for (int k = 0; k < 6; k++) add_pkt(4, 0, 0, 0, 4'd0, 4'd0, 1);
    repeat (12) @(posedge clk);
    #1;
    check(in_bp[4] == 1, "R2", 32'(in_bp[4]), 32'd1);
    check(src_idx[4] - base == 4, "R2", 32'(src_idx[4] - base), 32'd4);
    check(out_vld[4] == 1, "R3", 32'(out_vld[4]), 32'd1);
    check(out_flit[4*W +: W] == exp_head[n_pk - 6], "R3", out_flit[4*W +: W], exp_head[n_pk - 6]);
    repeat (3) @(posedge clk);
    #1;
    check(out_flit[4*W +: W] == exp_head[n_pk - 6], "R3", out_flit[4*W +: W], exp_head[n_pk - 6]);
    @(negedge clk); bp_force[4] = 0;
    wait (n_done == n_pk);

    // R5/R6/R7 corners: long way round, Y-first with Y spent, X spent
    add_pkt(0, 0, 1, 0, 4'd15, 4'd2, 3);
    add_pkt(1, 1, 0, 1, 4'd2, 4'd0, 2);
    add_pkt(2, 0, 0, 1, 4'd0, 4'd3, 4);
    add_pkt(3, 1, 1, 0, 4'd1, 4'd15, 1);
    wait (n_done == n_pk);

    // mixed random traffic with gaps and random backpressure
    gaps_en = 1; bp_rand_en = 1;
    for (int r = 0; r < 30; r++)
      for (int i = 0; i < NP; i++) begin
        logic [3:0] xh, yh;
        xh = ($urandom_range(9) == 0) ? 4'd15 : 4'($urandom_range(3));
        yh = ($urandom_range(9) == 0) ? 4'd15 : 4'($urandom_range(3));
        add_pkt(i, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                xh, yh, $urandom_range(1, 4));
      end
    wait (n_done == n_pk);
    repeat (4) @(posedge clk);
    #1;
    check(out_vld == '0 || bp_rand_en, "R8", 32'(out_vld), 32'd0);
    check(n_done == n_pk, "R8", 32'(n_done), 32'(n_pk));
    finish_up();
  end
endmodule